// File: doc/BRIEF.md
# Shift and Logic ALU with Condition Flags

This block is the arithmetic and logic unit of a small 32-bit processor datapath. It takes two operands, a four-bit operation code and the current negative, zero, carry and overflow flags. It returns a result word and the next value of each flag. It covers addition, subtraction, five bitwise operations and four shift or rotate operations. The shift amount is the whole low byte of the second operand, so any value from 0 to 255 is legal. Each shift has a defined result and carry for amounts at or beyond the word width.

Result and flags are registered, so they appear one clock after the inputs are presented. The flag register that holds N, Z, C and V between instructions sits outside the block. The caller feeds the held flags back into the flag inputs. Each operation either produces a new flag value or passes the incoming value through unchanged. The datapath width is a parameter and must be a power of two. The shift-amount width is also a parameter and must be wider than log2 of the datapath width.

Top module: `shift_logic_alu`

## Requirements
- R1: Op 0 (add) gives a+b and op 1 (subtract) gives a-b, both modulo 2^32. Both update N and Z and pass C through unchanged.
- R2: For every op code from 0 to 10, next N equals bit 31 of the result, and next Z is 1 exactly when the result is zero.
- R3: The bitwise ops are AND (2), XOR (3), OR (4), a AND NOT b (5) and NOT b (6). Each passes C through unchanged.
- R4: Shift ops 7 to 10 take their amount from b[7:0] only. Bits b[31:8] have no effect on the result or on the flags.
- R5: For a shift op with an amount of zero, the result equals a and C passes through unchanged.
- R6: Op 7 (logical left) and op 8 (logical right) fill vacated bits with zeros, and C is the last bit shifted out. At an amount of exactly 32 the result is 0, and C is a[0] for left or a[31] for right. Above 32, both the result and C are 0.
- R7: Op 9 (arithmetic right) fills vacated bits with a[31], and C is the last bit shifted out. At an amount of 32 or more, every result bit and C equal a[31].
- R8: Op 10 (rotate right) rotates by the amount modulo 32. For any nonzero amount, C equals bit 31 of the result. This means C is a[31] when the amount is a nonzero multiple of 32.
- R9: Next V equals the incoming V for every op code.
- R10: Op codes 11 to 15 are reserved. They return a unchanged, and all four flags pass through unchanged.
- R11: Outputs change one clock after the inputs. A synchronous active-high reset clears the result and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand, the value that is shifted |
| b_i | input | 32 | Second operand; its low byte is the shift amount |
| n_i | input | 1 | Current negative flag |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| res_o | output | 32 | Registered result |
| n_o | output | 1 | Registered next negative flag |
| z_o | output | 1 | Registered next zero flag |
| c_o | output | 1 | Registered next carry flag |
| v_o | output | 1 | Registered next overflow flag |

## Verification
The assertions check the following on every clock:
- N and Z track the registered result.
- V follows the previous cycle's input.
- A zero-amount shift holds the operand and the carry.
- NOT b is produced for op 6.
- Logical left shifts by more than 32 clear both the result and the carry.

The exact bit patterns and carry values of the remaining cases can only be shown by the bench's sweeps. These cover every amount from 0 to 255 for each shift over several operands, masked upper bits of b, and the reserved op codes. The bench compares each case against a model that shifts one bit at a time.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_EOR = 4'd3,
    OP_ORR = 4'd4,
    OP_BIC = 4'd5,
    OP_MVN = 4'd6,
    OP_LSL = 4'd7,
    OP_LSR = 4'd8,
    OP_ASR = 4'd9,
    OP_ROR = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 32
) (
  input  alu_pkg::alu_op_e op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     res_o
);
  import alu_pkg::*;
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_EOR:  res_o = a_i ^ b_i;
      OP_ORR:  res_o = a_i | b_i;
      OP_BIC:  res_o = a_i & ~b_i;
      OP_MVN:  res_o = ~b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  alu_pkg::shift_kind_e kind_i,
  input  logic [W-1:0]         a_i,
  input  logic [AMT_W-1:0]     amt_i,
  input  logic                 c_i,
  output logic [W-1:0]         res_o,
  output logic                 c_o
);
  import alu_pkg::*;
  localparam int SW = $clog2(W);
  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(W);

  logic             amt_zero, amt_below, amt_equal;
  logic [SW-1:0]    amt_lo;
  logic [AMT_W-1:0] left_idx_full, right_idx_full;
  logic [SW-1:0]    left_idx, right_idx;
  logic [W-1:0]     lsl_v, lsr_v, asr_v, ror_v;
  logic             lsl_c, lsr_c, asr_c, ror_c;

  always_comb begin
    amt_zero       = (amt_i == '0);
    amt_below      = (amt_i < WIDTH_AMT);
    amt_equal      = (amt_i == WIDTH_AMT);
    amt_lo         = amt_i[SW-1:0];
    // index of the last bit to leave the word, valid for 1..W
    left_idx_full  = WIDTH_AMT - amt_i;
    right_idx_full = amt_i - AMT_W'(1);
    left_idx       = left_idx_full[SW-1:0];
    right_idx      = right_idx_full[SW-1:0];

    lsl_v = amt_below ? (a_i << amt_lo) : '0;
    lsl_c = (amt_below || amt_equal) ? a_i[left_idx] : 1'b0;

    lsr_v = amt_below ? (a_i >> amt_lo) : '0;
    lsr_c = (amt_below || amt_equal) ? a_i[right_idx] : 1'b0;

    asr_v = amt_below ? W'($signed(a_i) >>> amt_lo) : {W{a_i[W-1]}};
    asr_c = amt_below ? a_i[right_idx] : a_i[W-1];

    ror_v = (a_i >> amt_lo) | (a_i << (W - int'(amt_lo)));
    ror_c = ror_v[W-1];

    unique case (kind_i)
      SH_LSL: begin res_o = lsl_v; c_o = lsl_c; end
      SH_LSR: begin res_o = lsr_v; c_o = lsr_c; end
      SH_ASR: begin res_o = asr_v; c_o = asr_c; end
      default: begin res_o = ror_v; c_o = ror_c; end
    endcase

    if (amt_zero) begin
      res_o = a_i;
      c_o   = c_i;
    end
  end
endmodule

// File: rtl/shift_logic_alu.sv
module shift_logic_alu #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         n_i,
  input  logic         z_i,
  input  logic         c_i,
  input  logic         v_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o
);
  import alu_pkg::*;

  alu_op_e     op;
  shift_kind_e kind;
  logic [W-1:0] sum_w, bit_w, sh_w, res_d;
  logic         sh_c, n_d, z_d, c_d;
  logic         is_arith, is_logic, is_shift;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.W(W)) u_addsub (
    .sub_i(op_i == OP_SUB), .a_i(a_i), .b_i(b_i), .sum_o(sum_w)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(bit_w)
  );

  alu_shift #(.W(W), .AMT_W(AMT_W)) u_shift (
    .kind_i(kind), .a_i(a_i), .amt_i(b_i[AMT_W-1:0]), .c_i(c_i),
    .res_o(sh_w), .c_o(sh_c)
  );

  always_comb begin
    is_arith = (op_i <= 4'(OP_SUB));
    is_logic = (op_i >= 4'(OP_AND)) && (op_i <= 4'(OP_MVN));
    is_shift = (op_i >= 4'(OP_LSL)) && (op_i <= 4'(OP_ROR));
    unique case (op_i)
      4'(OP_LSL): kind = SH_LSL;
      4'(OP_LSR): kind = SH_LSR;
      4'(OP_ASR): kind = SH_ASR;
      default:    kind = SH_ROR;
    endcase

    res_d = a_i;
    c_d   = c_i;
    if (is_arith)      res_d = sum_w;
    else if (is_logic) res_d = bit_w;
    else if (is_shift) begin
      res_d = sh_w;
      c_d   = sh_c;
    end

    if (is_arith || is_logic || is_shift) begin
      n_d = res_d[W-1];
      z_d = (res_d == '0);
    end else begin
      n_d = n_i;
      z_d = z_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      n_o   <= 1'b0;
      z_o   <= 1'b0;
      c_o   <= 1'b0;
      v_o   <= 1'b0;
    end else begin
      res_o <= res_d;
      n_o   <= n_d;
      z_o   <= z_d;
      c_o   <= c_d;
      v_o   <= v_i;
    end
  end

  // R2: N and Z follow the registered result for defined op codes
  a_r2_nz_track: assert property (@(posedge clk) disable iff (rst)
    (op_i <= 4'(OP_ROR)) |=> (n_o == res_o[W-1]) && (z_o == (res_o == '0)));

  // R9: overflow flag follows the previous input
  a_r9_v_pass: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (v_o == $past(v_i)));

  // R5: zero amount shift keeps operand and carry
  a_r5_zero_amt: assert property (@(posedge clk) disable iff (rst)
    ((op_i >= 4'(OP_LSL)) && (op_i <= 4'(OP_ROR)) && (b_i[AMT_W-1:0] == '0))
    |=> (res_o == $past(a_i)) && (c_o == $past(c_i)));

  // R3: inversion op returns NOT b
  a_r3_mvn: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'(OP_MVN)) |=> (res_o == ~$past(b_i)));

  // R6: left shift beyond the width clears result and carry
  a_r6_lsl_far: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 4'(OP_LSL)) && (b_i[AMT_W-1:0] > AMT_W'(W)))
    |=> (res_o == '0) && !c_o);
endmodule

// File: tb/shift_logic_alu_bench.sv
`timescale 1ns/1ps
module shift_logic_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op  = '0;
  logic [31:0] a = '0, b = '0;
  logic        n_i = 0, z_i = 0, c_i = 0, v_i = 0;
  logic [31:0] res;
  logic        n_o, z_o, c_o, v_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  shift_logic_alu u_shift_logic_alu (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b),
    .n_i(n_i), .z_i(z_i), .c_i(c_i), .v_i(v_i),
    .res_o(res), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference: one bit per step
  function automatic logic [35:0] model(input logic [3:0] o, input logic [31:0] x,
      input logic [31:0] y, input logic n, input logic z, input logic c, input logic v);
    logic [31:0] r;
    logic cc, defined;
    int amt;
    r = x; cc = c; defined = 1'b1;
    amt = int'(y[7:0]);
    case (o)
      4'd0: r = x + y;
      4'd1: r = x + ~y + 32'd1;
      4'd2: r = x & y;
      4'd3: r = x ^ y;
      4'd4: r = x | y;
      4'd5: r = x & ~y;
      4'd6: r = ~y;
      4'd7: for (int i = 0; i < amt; i++) begin cc = r[31]; r = {r[30:0], 1'b0}; end
      4'd8: for (int i = 0; i < amt; i++) begin cc = r[0]; r = {1'b0, r[31:1]}; end
      4'd9: for (int i = 0; i < amt; i++) begin cc = r[0]; r = {r[31], r[31:1]}; end
      4'd10: for (int i = 0; i < amt; i++) begin cc = r[0]; r = {r[0], r[31:1]}; end
      default: defined = 1'b0;
    endcase
    if (defined) return {r, r[31], (r == 0), cc, v};
    return {r, n, z, cc, v};
  endfunction

  task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [3:0] flags, input string force_tag);
    logic [35:0] e;
    string t;
    @(negedge clk);
    op = o; a = x; b = y; {n_i, z_i, c_i, v_i} = flags;
    e = model(o, x, y, flags[3], flags[2], flags[1], flags[0]);
    @(negedge clk);
    if (force_tag != "") t = force_tag;
    else if (o <= 4'd1) t = "R1";
    else if (o <= 4'd6) t = "R3";
    else if (o >= 4'd11) t = "R10";
    else if (y[7:0] == 8'd0) t = "R5";
    else if (o <= 4'd8) t = "R6";
    else if (o == 4'd9) t = "R7";
    else t = "R8";
    chk(t, "result", res, e[35:4]);
    chk(t, "carry", {31'd0, c_o}, {31'd0, e[1]});
    chk((o >= 4'd11) ? "R10" : "R2", "N", {31'd0, n_o}, {31'd0, e[3]});
    chk((o >= 4'd11) ? "R10" : "R2", "Z", {31'd0, z_o}, {31'd0, e[2]});
    chk("R9", "V", {31'd0, v_o}, {31'd0, e[0]});
  endtask

  logic [31:0] pats [6] = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFE,
                            32'hA5C3_0F96, 32'h0000_0000, 32'h1234_5678};

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset result", res, 32'h0);
    chk("R11", "reset flags", {28'd0, n_o, z_o, c_o, v_o}, 32'h0);
    rst = 1'b0;
    // R11: one-clock latency
    @(negedge clk);
    op = 4'd0; a = 32'd5; b = 32'd7; v_i = 1'b1;
    #1 chk("R11", "before edge", res, 32'h0);
    @(negedge clk);
    chk("R11", "after edge", res, 32'd12);

    // R1 and R3: arithmetic and logic over operand pairs
    for (int o = 0; o <= 6; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run(4'(o), pats[i], pats[j], 4'(i + j + o), "");

    // R6 R7 R8 R5: all amounts for every shift and pattern
    for (int o = 7; o <= 10; o++)
      for (int i = 0; i < 6; i++)
        for (int s = 0; s < 256; s++)
          run(4'(o), pats[i], 32'(s), {2'b01, 1'(s), 1'(s >> 1)}, "");

    // R4: upper bits of b must be masked
    for (int o = 7; o <= 10; o++)
      for (int s = 0; s < 70; s++)
        run(4'(o), 32'hC0DE_1357, {24'hA5F00D ^ 24'(s * 977), 8'(s)}, 4'b1010, "R4");

    // R10: reserved op codes
    for (int o = 11; o <= 15; o++)
      for (int i = 0; i < 6; i++)
        run(4'(o), pats[i], pats[5 - i], 4'(i * 3 + o), "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("watchdog expired before the run completed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule